// File: doc/BRIEF.md
# Paced Backend Memory Access Port

This block sits between a remote terminal's protocol logic and a word-addressed backend store of 2048 sixteen-bit words, or any other device that answers to a word address. The protocol side gives a direction bit, a 5-bit subaddress, a 5-bit word index, a read/write flag and write data. The port turns these into an 11-bit memory address. It asks for the backend bus, waits for a grant and performs one read or write. It then returns a one-cycle completion pulse, which carries the read data on a read.

Accesses are deliberately slow. A free-running slot counter divides time into fixed windows of `SLOT` cycles, which is 100 cycles at 50 MHz, or 2 µs. A new access can begin only at the opening of a window, so two accesses are never closer than one window apart. The port can drive a synchronous memory or an asynchronous one:
- A synchronous memory has registered read data. Its strobe lasts one cycle, and the data is taken in the following cycle.
- An asynchronous memory keeps its strobe held for a configured number of cycles, and the data is taken at the end of that hold.

In either mode a wait input holds the strobe for as long as the device asks. A remap input selects a second address layout that keeps the receive and transmit buffers of each subaddress next to each other.

The controller has six states:
- `ST_IDLE`: waits for a request at an open slot, then goes to `ST_REQ`.
- `ST_REQ`: holds the bus request. On grant it goes to `ST_SYNC` or `ST_ASYNC`.
- `ST_SYNC`: drives the strobe. When wait is low it goes to `ST_SCAP`.
- `ST_SCAP`: captures the read data, then goes to `ST_DONE`.
- `ST_ASYNC`: drives the strobe. Once the hold count is reached and wait is low, it captures the data and goes to `ST_DONE`.
- `ST_DONE`: pulses completion, then returns to `ST_IDLE`.

Top module: `slot_mem_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `bus_req`, `mem_rd_en`, `mem_wr_en` and `xfer_done` are all 0.
- R2: With `cfg_remap`=0 the address is formed as follows: bit 10 is `xfer_tx`, bits 9:5 are `xfer_sa` and bits 4:0 are `xfer_wi`.
- R3: With `cfg_remap`=1 the address is formed as follows: bits 10:6 are `xfer_sa`, bit 5 is `xfer_tx` and bits 4:0 are `xfer_wi`.
- R4: `bus_req` rises only on slot boundaries, so the cycle numbers of any two rises differ by a multiple of `SLOT`.
- R5: Neither strobe is asserted without `bus_req`. A strobe starts only in the cycle after `bus_gnt` was seen high, and none is driven while the grant is withheld.
- R6: In synchronous mode (`cfg_async`=0) the strobe lasts 1 cycle plus one cycle for each cycle in which `mem_wait` is high during the strobe. `xfer_done` comes 2 cycles after the last strobe cycle, and it returns the `mem_rdata` value presented in the cycle after the strobe.
- R7: In asynchronous mode (`cfg_async`=1) the strobe lasts at least max(`cfg_hold`,1) cycles. While the hold count is not yet reached, a high `mem_wait` has no extra effect. Each further cycle of `mem_wait` adds one cycle. `xfer_done` comes in the cycle after the last strobe cycle, and it returns the `mem_rdata` seen in that last cycle.
- R8: During a write strobe `mem_wdata` equals the `xfer_wdata` given with the request, and it stays stable together with `mem_addr`. Read and write strobes are never high together.
- R9: `xfer_done` is a single-cycle pulse with `bus_req` low. `bus_req` stays high from its rise until the cycle before `xfer_done`.
- R10: A request held high continuously, or raised again right after completion, starts its next access no sooner than `SLOT` cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_async | input | 1 | 1 selects asynchronous memory timing |
| cfg_remap | input | 1 | 1 selects the alternative address layout |
| cfg_hold | input | 4 | Asynchronous strobe hold in cycles; 0 is treated as 1 |
| xfer_req | input | 1 | Access request, held until `xfer_done` |
| xfer_wr | input | 1 | 1 = write, 0 = read |
| xfer_tx | input | 1 | Direction bit placed in the address |
| xfer_sa | input | 5 | Subaddress |
| xfer_wi | input | 5 | Word index within the subaddress |
| xfer_wdata | input | 16 | Write data |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_rdata | output | 16 | Read data, valid with `xfer_done` |
| bus_req | output | 1 | Backend bus request |
| bus_gnt | input | 1 | Backend bus grant |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_rdata | input | 16 | Memory read data |
| mem_wait | input | 1 | Device wait; stretches the strobe |

## Verification
The assertions take for granted that the protocol side keeps `xfer_req` and its fields steady from the request until `xfer_done`. They also assume that the configuration inputs do not change while an access is in flight. The stimulus keeps to this: it changes modes, hold counts and transfer fields only between accesses, and it drops the request on the completion cycle. Grant delays and wait lengths are random but bounded, so every access still ends well inside the bench's time limit.

// File: rtl/slot_mem_pkg.sv
package slot_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SYNC,
        ST_SCAP,
        ST_ASYNC,
        ST_DONE
    } port_state_t;

endpackage

// File: rtl/slot_pacer.sv
module slot_pacer #(
    parameter int SLOT = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_open
);
    localparam int CNT_W = (SLOT > 1) ? $clog2(SLOT) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(SLOT - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot_open = (cnt_q == '0);

endmodule

// File: rtl/slot_addr_map.sv
module slot_addr_map #(
    parameter int SA_W = 5,
    parameter int WI_W = 5,
    localparam int ADDR_W = 1 + SA_W + WI_W
) (
    input  logic              remap,
    input  logic              tx,
    input  logic [SA_W-1:0]   sa,
    input  logic [WI_W-1:0]   wi,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        if (remap) begin
            addr = {sa, tx, wi};
        end else begin
            addr = {tx, sa, wi};
        end
    end

endmodule

// File: rtl/slot_hold_timer.sv
module slot_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HOLD_W-1:0] cycles,
    output logic              reached
);
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] target;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= HOLD_W'(1);
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign target  = (cycles == '0) ? HOLD_W'(1) : cycles;
    assign reached = (cnt_q >= target);

endmodule

// File: rtl/slot_mem_port.sv
module slot_mem_port
    import slot_mem_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SA_W   = 5,
    parameter int WI_W   = 5,
    parameter int SLOT   = 100,
    parameter int HOLD_W = 4,
    localparam int ADDR_W = 1 + SA_W + WI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_async,
    input  logic              cfg_remap,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              xfer_req,
    input  logic              xfer_wr,
    input  logic              xfer_tx,
    input  logic [SA_W-1:0]   xfer_sa,
    input  logic [WI_W-1:0]   xfer_wi,
    input  logic [DATA_W-1:0] xfer_wdata,
    output logic              xfer_done,
    output logic [DATA_W-1:0] xfer_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_wait
);
    port_state_t state_q, state_d;

    logic              slot_open;
    logic              hold_start;
    logic              hold_reached;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_q;
    logic              async_q;
    logic              accept;
    logic              async_end;
    logic              strobe;

    slot_pacer #(.SLOT(SLOT)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_open (slot_open)
    );

    slot_addr_map #(.SA_W(SA_W), .WI_W(WI_W)) u_map (
        .remap (cfg_remap),
        .tx    (xfer_tx),
        .sa    (xfer_sa),
        .wi    (xfer_wi),
        .addr  (map_addr)
    );

    slot_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (hold_start),
        .cycles  (cfg_hold),
        .reached (hold_reached)
    );

    assign accept     = (state_q == ST_IDLE) && xfer_req && slot_open;
    assign hold_start = (state_q == ST_REQ) && bus_gnt;
    assign async_end  = (state_q == ST_ASYNC) && hold_reached && !mem_wait;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_REQ;
            ST_REQ:   if (bus_gnt)   state_d = async_q ? ST_ASYNC : ST_SYNC;
            ST_SYNC:  if (!mem_wait) state_d = ST_SCAP;
            ST_SCAP:                 state_d = ST_DONE;
            ST_ASYNC: if (async_end) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // access registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            async_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= map_addr;
                wdata_q <= xfer_wdata;
                wr_q    <= xfer_wr;
                async_q <= cfg_async;
            end
            if (!wr_q && ((state_q == ST_SCAP) || async_end)) begin
                rdata_q <= mem_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        strobe    = 1'b0;
        xfer_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_REQ:   bus_req = 1'b1;
            ST_SYNC:  begin bus_req = 1'b1; strobe = 1'b1; end
            ST_SCAP:  bus_req = 1'b1;
            ST_ASYNC: begin bus_req = 1'b1; strobe = 1'b1; end
            ST_DONE:  xfer_done = 1'b1;
            default:  ;
        endcase
    end

    assign mem_rd_en  = strobe && !wr_q;
    assign mem_wr_en  = strobe && wr_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign xfer_rdata = rdata_q;

endmodule

// File: rtl/slot_mem_port_chk.sv
module slot_mem_port_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11,
    parameter int SLOT   = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              xfer_done
);
    logic        req_d;
    logic [31:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_d <= 1'b0;
            gap_q <= 32'(SLOT);
        end else begin
            req_d <= bus_req;
            if (bus_req && !req_d) begin
                gap_q <= 32'd1;
            end else if (gap_q < 32'(SLOT)) begin
                gap_q <= gap_q + 32'd1;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !mem_rd_en && !mem_wr_en && !xfer_done));

    p_strobe_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> bus_req);

    p_strobe_after_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en || mem_wr_en) |-> $past(bus_gnt));

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_write_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> ($stable(mem_wdata) && $stable(mem_addr)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    p_done_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!bus_req && $past(bus_req)));

    p_slot_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !req_d) |-> (gap_q >= 32'(SLOT)));

endmodule

bind slot_mem_port slot_mem_port_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SLOT   (SLOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .xfer_done (xfer_done)
);

// File: tb/slot_mem_port_tb.sv
`timescale 1ns/1ps
module slot_mem_port_tb;
    localparam int SLOT = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_async = 1'b0, cfg_remap = 1'b0;
    logic [3:0]  cfg_hold = 4'd0;
    logic        xfer_req = 1'b0, xfer_wr = 1'b0, xfer_tx = 1'b0;
    logic [4:0]  xfer_sa = '0, xfer_wi = '0;
    logic [15:0] xfer_wdata = '0;
    logic        xfer_done;
    logic [15:0] xfer_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_rdata;
    logic        mem_wait = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0;
    int first_start = -1, prev_start = -1;
    bit finished = 1'b0;

    logic [15:0] bmem   [0:2047];
    logic [15:0] shadow [0:2047];
    logic [15:0] sync_q = '0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
        if (mem_rd_en) sync_q <= bmem[mem_addr];
    end
    assign mem_rdata = cfg_async ? bmem[mem_addr] : sync_q;

    slot_mem_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_async(cfg_async), .cfg_remap(cfg_remap),
        .cfg_hold(cfg_hold), .xfer_req(xfer_req), .xfer_wr(xfer_wr), .xfer_tx(xfer_tx),
        .xfer_sa(xfer_sa), .xfer_wi(xfer_wi), .xfer_wdata(xfer_wdata),
        .xfer_done(xfer_done), .xfer_rdata(xfer_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata),
        .mem_wait(mem_wait)
    );

    function automatic logic [10:0] exp_addr(bit remap, bit tx, logic [4:0] sa, logic [4:0] wi);
        return remap ? {sa, tx, wi} : {tx, sa, wi};
    endfunction

    function automatic int exp_strobe_len(bit async_m, int hold, int waits);
        int eff;
        if (!async_m) return 1 + waits;
        eff = (hold == 0) ? 1 : hold;
        return (waits + 1 > eff) ? waits + 1 : eff;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic run_access(bit tx, logic [4:0] sa, logic [4:0] wi, bit wr,
                              logic [15:0] wd, int gnt_dly, int waits);
        logic [10:0] ea;
        int n, start, len, d, exp_len, gap;
        bit bad;
        ea = exp_addr(cfg_remap, tx, sa, wi);
        @(negedge clk);
        xfer_req = 1'b1; xfer_tx = tx; xfer_sa = sa; xfer_wi = wi;
        xfer_wr = wr; xfer_wdata = wd;
        n = 0;
        while (!bus_req && n < 400) begin @(negedge clk); n++; end
        start = cyc;
        if (first_start < 0) first_start = start;
        chk(((start - first_start) % SLOT) == 0, "R4 slot-aligned start", start - first_start, SLOT);
        if (prev_start >= 0) begin
            gap = start - prev_start;
            chk(gap >= SLOT, "R10 start spacing", gap, SLOT);
        end
        prev_start = start;
        bad = 1'b0;
        for (int i = 0; i < gnt_dly; i++) begin
            if (mem_rd_en || mem_wr_en || !bus_req) bad = 1'b1;
            @(negedge clk);
        end
        chk(!bad, "R5 no strobe before grant", bad, 0);
        bus_gnt = 1'b1;
        @(negedge clk);
        chk(mem_rd_en == !wr && mem_wr_en == wr, "R5 strobe after grant", {mem_rd_en, mem_wr_en}, {!wr, wr});
        chk(mem_addr == ea, cfg_remap ? "R3 remapped address" : "R2 default address", mem_addr, ea);
        len = 0; bad = 1'b0;
        while ((mem_rd_en || mem_wr_en) && len < 64) begin
            if (mem_addr != ea || !bus_req) bad = 1'b1;
            if (wr && mem_wdata != wd) bad = 1'b1;
            mem_wait = (len < waits);
            len++;
            @(negedge clk);
        end
        mem_wait = 1'b0;
        chk(!bad, "R8 address/data held during strobe", bad, 0);
        exp_len = exp_strobe_len(cfg_async, cfg_hold, waits);
        chk(len == exp_len, cfg_async ? "R7 async strobe length" : "R6 sync strobe length", len, exp_len);
        d = 1;
        while (!xfer_done && d < 10) begin
            if (!bus_req) bad = 1'b1;
            @(negedge clk); d++;
        end
        chk(d == (cfg_async ? 1 : 2), cfg_async ? "R7 done latency" : "R6 done latency", d, cfg_async ? 1 : 2);
        chk(xfer_done && !bus_req && !bad, "R9 done with request low", {xfer_done, bus_req}, 2);
        if (!wr) chk(xfer_rdata == shadow[ea], cfg_async ? "R7 read data" : "R6 read data", xfer_rdata, shadow[ea]);
        else shadow[ea] = wd;
        xfer_req = 1'b0; bus_gnt = 1'b0;
        @(negedge clk);
        chk(!xfer_done, "R9 done single cycle", xfer_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) begin
            v = 16'($urandom);
            bmem[i] = v; shadow[i] = v;
        end
        repeat (3) @(negedge clk);
        chk(!bus_req && !mem_rd_en && !mem_wr_en && !xfer_done, "R1 outputs quiet in reset",
            {bus_req, mem_rd_en, mem_wr_en, xfer_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !mem_rd_en && !mem_wr_en && !xfer_done, "R1 outputs quiet after reset",
            {bus_req, mem_rd_en, mem_wr_en, xfer_done}, 0);

        // directed corners
        cfg_async = 0; cfg_remap = 0;
        run_access(1'b1, 5'd31, 5'd31, 1'b1, 16'hA5C3, 0, 0);    // R2 top address
        run_access(1'b1, 5'd31, 5'd31, 1'b0, 16'h0000, 3, 2);    // R6 read back with waits
        cfg_remap = 1;
        run_access(1'b0, 5'd1, 5'd0, 1'b1, 16'h1234, 1, 0);      // R3 layout
        run_access(1'b0, 5'd1, 5'd0, 1'b0, 16'h0000, 0, 0);
        cfg_async = 1; cfg_hold = 4'd0;                          // R7 zero hold acts as one
        run_access(1'b1, 5'd7, 5'd9, 1'b0, 16'h0000, 2, 0);
        cfg_hold = 4'd5;                                         // R7 wait inside hold ignored
        run_access(1'b0, 5'd3, 5'd4, 1'b1, 16'hBEEF, 0, 3);
        run_access(1'b0, 5'd3, 5'd4, 1'b0, 16'h0000, 0, 7);      // R7 wait beyond hold

        // constrained random
        for (int k = 0; k < 40; k++) begin
            cfg_async = 1'($urandom);
            cfg_remap = 1'($urandom);
            cfg_hold  = 4'($urandom_range(0, 6));
            run_access(1'($urandom), 5'($urandom), 5'($urandom), 1'($urandom),
                       16'($urandom), $urandom_range(0, 4), $urandom_range(0, 4));
        end
        finish_run();
    end
endmodule